// File: doc/BRIEF.md
# Programmable External Memory Strobe Sequencer

This block runs single read and write accesses on a non-multiplexed asynchronous SRAM bus for a small processor core. The core presents one request at a time: a direction, an address and, for writes, a data byte. The block drives the address bus, the write-data bus with its output enable and two active-low strobes, one for read and one for write. It then raises a one-cycle completion pulse. On a read, the captured data is on the read-data output by the time that pulse appears.

Every access starts with three fixed overhead cycles. After that come three phases whose lengths come from an 8-bit timing register that the core can write. The first phase is an address setup time of 0 to 3 cycles with both strobes high. The second is a strobe phase of 1 to 16 cycles. The third is an address hold time of 0 to 3 cycles with both strobes high again. Reset loads the slowest setting into the register. A register write issued while an access is running is parked and committed when that access finishes. The running access always uses the timing it was accepted with.

Top module: `xseq_top`

## Requirements
- R1: After reset the timing register reads 8'hFF (setup 3, strobe 16, hold 3), both strobes are high, the output enable and done are low, and req_ready is high.
- R2: Timing register layout: bits [7:6] are the setup code s, bits [5:2] are the strobe code w, bits [1:0] are the hold code h. cfg_rdata returns the committed value.
- R3: A request is accepted on a clock edge where req_valid and req_ready are both high. Counting that edge as cycle 0, done is high in cycle T+1, where T = 4 + s + w + h. With all codes zero, T is 4.
- R4: The strobe of the access first goes low in cycle 4 + s, after three overhead cycles and s setup cycles.
- R5: The strobe stays low for exactly w + 1 consecutive cycles. Reads and writes use the same width.
- R6: After the strobe rises, exactly h cycles pass before done goes high.
- R7: Read data is sampled in the last strobe-low cycle. It appears on rd_data while done is high and is held through later writes until the next read.
- R8: During a write, mem_dout_oe is high from cycle 4 through cycle T, and mem_dout holds the request data. During a read, mem_dout_oe stays low.
- R9: Only the strobe that matches the direction is ever driven low. The two strobes are never low together.
- R10: done is a single-cycle pulse. req_ready is low from acceptance through the done cycle. A request presented while req_ready is low is ignored and starts no access.
- R11: A register write while idle is visible on cfg_rdata in the next cycle. A register write during an access leaves cfg_rdata unchanged until the access completes, and the value becomes visible in the cycle after done.
- R12: If a register write and a request acceptance happen in the same cycle, that access uses the old timing, and the new value governs later accesses.
- R13: mem_addr holds the request address from the cycle after acceptance through the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Sequencer idle, a request is taken this cycle |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Captured read data |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_wdata | input | 8 | Timing register write value |
| cfg_rdata | output | 8 | Committed timing register value |
| mem_addr | output | ADDR_W | External address bus |
| mem_dout | output | DATA_W | External write-data bus |
| mem_dout_oe | output | 1 | Write-data bus output enable |
| mem_din | input | DATA_W | External read-data bus |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_we_n | output | 1 | Active-low write strobe |

## Verification
Two events can land on the same clock edge: a timing register write and the acceptance of a new access. A second collision is a register write in the middle of an access against the commit of that access in its done cycle. The bench provokes the first by raising cfg_we and req_valid together while idle. It judges the result by checking that the strobe position and width follow the old fields while cfg_rdata already shows the new value. It provokes the second with writes at random points inside an access, and checks that cfg_rdata stays frozen until the cycle after done and that the next access follows the new fields.

// File: rtl/xseq_pkg.sv
package xseq_pkg;

  // Phases of one external access, in the order they occur.
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_OVH   = 3'd1,
    PH_SETUP = 3'd2,
    PH_STRB  = 3'd3,
    PH_HOLD  = 3'd4,
    PH_DONE  = 3'd5
  } phase_t;

  // Timing control word; the field order fixes the bit positions.
  typedef struct packed {
    logic [1:0] setup;   // [7:6]
    logic [3:0] width;   // [5:2] strobe cycles minus one
    logic [1:0] hold;    // [1:0]
  } timing_t;

  localparam int TIMING_W = $bits(timing_t);
  localparam logic [TIMING_W-1:0] TIMING_RESET = '1;

endpackage

// File: rtl/xseq_timing_reg.sv
module xseq_timing_reg
  import xseq_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_open,   // idle or completing: commits allowed
  input  logic                cfg_we,
  input  logic [TIMING_W-1:0] cfg_wdata,
  output timing_t             cfg_q
);

  logic                pend_v;
  logic [TIMING_W-1:0] pend_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= timing_t'(TIMING_RESET);
      pend_v <= 1'b0;
      pend_d <= '0;
    end else if (cfg_open) begin
      // the latest write wins over a parked one
      if (cfg_we) begin
        cfg_q  <= timing_t'(cfg_wdata);
        pend_v <= 1'b0;
      end else if (pend_v) begin
        cfg_q  <= timing_t'(pend_d);
        pend_v <= 1'b0;
      end
    end else if (cfg_we) begin
      pend_v <= 1'b1;
      pend_d <= cfg_wdata;
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !cfg_open |=> $stable(cfg_q)); // R11

  AST_RESET_SLOW: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg_q == timing_t'(TIMING_RESET))); // R1

endmodule

// File: rtl/xseq_phase_ctrl.sv
module xseq_phase_ctrl
  import xseq_pkg::*;
#(
  parameter int OVH_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       start_write,
  input  timing_t    tcfg,
  output phase_t     phase_q,
  output phase_t     phase_nxt,
  output logic       wr_q,
  output logic       capture,
  output logic [3:0] width_q
);

  localparam int OVH_W = $clog2(OVH_CYCLES + 1);
  localparam int CNT_W = (OVH_W > 4) ? OVH_W : 4;

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [1:0]       setup_q, hold_q;

  always_comb begin
    phase_nxt = phase_q;
    cnt_n     = cnt_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_nxt = PH_OVH;
          cnt_n     = CNT_W'(OVH_CYCLES - 1);
        end
      end
      PH_OVH: begin
        if (cnt_q == '0) begin
          if (setup_q != 2'd0) begin
            phase_nxt = PH_SETUP;
            cnt_n     = CNT_W'(setup_q - 2'd1);
          end else begin
            phase_nxt = PH_STRB;
            cnt_n     = CNT_W'(width_q);
          end
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          phase_nxt = PH_STRB;
          cnt_n     = CNT_W'(width_q);
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      PH_STRB: begin
        if (cnt_q == '0) begin
          if (hold_q != 2'd0) begin
            phase_nxt = PH_HOLD;
            cnt_n     = CNT_W'(hold_q - 2'd1);
          end else begin
            phase_nxt = PH_DONE;
          end
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      PH_HOLD: begin
        if (cnt_q == '0) phase_nxt = PH_DONE;
        else             cnt_n     = cnt_q - 1'b1;
      end
      PH_DONE: phase_nxt = PH_IDLE;
      default: phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      setup_q <= '0;
      width_q <= '0;
      hold_q  <= '0;
    end else begin
      phase_q <= phase_nxt;
      cnt_q   <= cnt_n;
      if (phase_q == PH_IDLE && start) begin
        // timing is frozen for the whole access at acceptance
        wr_q    <= start_write;
        setup_q <= tcfg.setup;
        width_q <= tcfg.width;
        hold_q  <= tcfg.hold;
      end
    end
  end

  assign capture = (phase_q == PH_STRB) && (cnt_q == '0) && !wr_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_DONE) |=> (phase_q == PH_IDLE)); // R10

  AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_IDLE) |=> (phase_q != PH_OVH || $past(phase_q) == PH_OVH
                               || $past(phase_q) == PH_IDLE)); // R10

endmodule

// File: rtl/xseq_pins.sv
module xseq_pins
  import xseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  phase_t            phase_nxt,
  input  logic              wr_q,
  input  logic              capture,
  input  logic [3:0]        width_q,
  input  logic [DATA_W-1:0] mem_din,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_oe,
  output logic              mem_rd_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] rd_data
);

  logic strobe_nxt, bus_nxt;

  assign strobe_nxt = (phase_nxt == PH_STRB);
  assign bus_nxt    = (phase_nxt == PH_SETUP) || (phase_nxt == PH_STRB) ||
                      (phase_nxt == PH_HOLD);

  // Pins are registered from the next phase so they line up with phase_q.
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr    <= '0;
      mem_dout    <= '0;
      mem_dout_oe <= 1'b0;
      mem_rd_n    <= 1'b1;
      mem_we_n    <= 1'b1;
      rd_data     <= '0;
    end else begin
      if (accept) begin
        mem_addr <= req_addr;
        mem_dout <= req_wdata;
      end
      mem_rd_n    <= !(strobe_nxt && !wr_q);
      mem_we_n    <= !(strobe_nxt &&  wr_q);
      mem_dout_oe <= bus_nxt && wr_q;
      if (capture) rd_data <= mem_din;
    end
  end

  // checker: length of the current strobe-low run
  logic [4:0] low_run;
  always_ff @(posedge clk) begin
    if (rst)                        low_run <= '0;
    else if (!mem_rd_n || !mem_we_n) low_run <= low_run + 5'd1;
    else                            low_run <= '0;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_n || mem_we_n)); // R9

  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd_n & mem_we_n) |-> (low_run == 5'(width_q) + 5'd1)); // R5

  AST_OE_NOT_READ: assert property (@(posedge clk) disable iff (rst)
    mem_dout_oe |-> mem_rd_n); // R8

endmodule

// File: rtl/xseq_top.sv
module xseq_top
  import xseq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int OVH_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_oe,
  input  logic [DATA_W-1:0] mem_din,
  output logic              mem_rd_n,
  output logic              mem_we_n
);

  phase_t     phase_q, phase_nxt;
  timing_t    cfg_q;
  logic       wr_q, capture, accept, cfg_open;
  logic [3:0] width_q;

  assign req_ready = (phase_q == PH_IDLE);
  assign done      = (phase_q == PH_DONE);
  assign accept    = req_valid && req_ready;
  assign cfg_open  = (phase_q == PH_IDLE) || (phase_q == PH_DONE);
  assign cfg_rdata = cfg_q;

  xseq_timing_reg u_treg (
    .clk       (clk),
    .rst       (rst),
    .cfg_open  (cfg_open),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_q     (cfg_q)
  );

  xseq_phase_ctrl #(.OVH_CYCLES(OVH_CYCLES)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start       (accept),
    .start_write (req_write),
    .tcfg        (cfg_q),
    .phase_q     (phase_q),
    .phase_nxt   (phase_nxt),
    .wr_q        (wr_q),
    .capture     (capture),
    .width_q     (width_q)
  );

  xseq_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk         (clk),
    .rst         (rst),
    .accept      (accept),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .phase_nxt   (phase_nxt),
    .wr_q        (wr_q),
    .capture     (capture),
    .width_q     (width_q),
    .mem_din     (mem_din),
    .mem_addr    (mem_addr),
    .mem_dout    (mem_dout),
    .mem_dout_oe (mem_dout_oe),
    .mem_rd_n    (mem_rd_n),
    .mem_we_n    (mem_we_n),
    .rd_data     (rd_data)
  );

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && !$past(req_ready)) |-> $stable(mem_addr)); // R13

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10

endmodule

// File: tb/xseq_top_bench.sv
module xseq_top_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, done;
  logic [7:0]  rd_data;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [15:0] mem_addr;
  logic [7:0]  mem_dout, mem_din;
  logic        mem_dout_oe, mem_rd_n, mem_we_n;

  always #4 clk = ~clk;   // 125 MHz

  xseq_top u_xseq_top (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .done(done), .rd_data(rd_data), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .mem_addr(mem_addr), .mem_dout(mem_dout),
    .mem_dout_oe(mem_dout_oe), .mem_din(mem_din), .mem_rd_n(mem_rd_n),
    .mem_we_n(mem_we_n)
  );

  // bus-side SRAM model: junk on the data bus whenever read strobe is high
  logic [7:0] bmem    [256];
  logic [7:0] exp_mem [256];
  logic       live = 1'b0;
  always_comb mem_din = mem_rd_n ? ~bmem[mem_addr[7:0]] : bmem[mem_addr[7:0]];
  always @(posedge mem_we_n) if (live) bmem[mem_addr[7:0]] <= mem_dout;

  int nvec = 0, nerr = 0;
  logic [7:0] cfg_m;
  logic [7:0] last_rd;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int f_setup(input logic [7:0] c); return int'(c[7:6]); endfunction
  function automatic int f_width(input logic [7:0] c); return int'(c[5:2]) + 1; endfunction
  function automatic int f_hold (input logic [7:0] c); return int'(c[1:0]); endfunction
  function automatic int f_total(input logic [7:0] c);
    return 3 + f_setup(c) + f_width(c) + f_hold(c);
  endfunction

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
    chk(cfg_rdata === v, "R11 idle write", int'(cfg_rdata), int'(v));
    cfg_m = v;
  endtask

  task automatic run_access(input bit wr, input logic [15:0] a, input logic [7:0] d,
                            input int cfg_k, input logic [7:0] cfg_v,
                            input bit same, input bit intrude);
    int s, w, h, tt, first_low, low_cnt, last_low, done_k;
    int bad_oe, bad_addr, bad_str, bad_cfg, bad_rdy;
    logic [7:0] cfg_run, cfg_after;
    bit lr, lw, eoe;
    s = f_setup(cfg_m); w = f_width(cfg_m); h = f_hold(cfg_m); tt = f_total(cfg_m);
    first_low = 0; low_cnt = 0; last_low = 0; done_k = 0;
    bad_oe = 0; bad_addr = 0; bad_str = 0; bad_cfg = 0; bad_rdy = 0;
    cfg_run   = same ? cfg_v : cfg_m;
    cfg_after = (same || cfg_k > 0) ? cfg_v : cfg_m;
    @(negedge clk);
    chk(req_ready === 1'b1, "R10 ready idle", int'(req_ready), 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    if (same) begin cfg_we = 1'b1; cfg_wdata = cfg_v; end
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    for (int k = 1; k <= 60; k++) begin
      lr = !mem_rd_n; lw = !mem_we_n;
      if (lr || lw) begin
        if (first_low == 0) first_low = k;
        low_cnt++; last_low = k;
      end
      if ((wr && lr) || (!wr && lw) || (lr && lw)) bad_str++;
      eoe = wr && (k >= 4) && (k <= tt);
      if (mem_dout_oe !== eoe || (eoe && mem_dout !== d)) bad_oe++;
      if (mem_addr !== a) bad_addr++;
      if (cfg_rdata !== cfg_run) bad_cfg++;
      if (req_ready !== 1'b0) bad_rdy++;
      if (done === 1'b1) begin done_k = k; break; end
      if (k == cfg_k) begin cfg_we = 1'b1; cfg_wdata = cfg_v; end
      if (intrude && k == 2) begin req_valid = 1'b1; req_addr = ~a; req_write = !wr; end
      @(negedge clk);
      cfg_we = 1'b0; req_valid = 1'b0;
    end
    chk(done_k == tt + 1, "R3 done cycle", done_k, tt + 1);
    chk(first_low == 4 + s, "R4 strobe start", first_low, 4 + s);
    chk(low_cnt == w, "R5 strobe width", low_cnt, w);
    chk(done_k - 1 - last_low == h, "R6 hold", done_k - 1 - last_low, h);
    chk(bad_str == 0, "R9 strobe select", bad_str, 0);
    chk(bad_oe == 0, "R8 output enable", bad_oe, 0);
    chk(bad_addr == 0, "R13 address held", bad_addr, 0);
    chk(bad_rdy == 0, "R10 ready busy", bad_rdy, 0);
    if (cfg_k > 0 || same) chk(bad_cfg == 0, "R11 R12 cfg frozen", bad_cfg, 0);
    if (!wr) begin
      chk(rd_data === exp_mem[a[7:0]], "R7 read data", int'(rd_data), int'(exp_mem[a[7:0]]));
      last_rd = exp_mem[a[7:0]];
    end else begin
      chk(rd_data === last_rd, "R7 read data held", int'(rd_data), int'(last_rd));
      exp_mem[a[7:0]] = d;
    end
    @(negedge clk);
    chk(done === 1'b0 && req_ready === 1'b1, "R10 done pulse", int'(done), 0);
    if (cfg_k > 0 || same)
      chk(cfg_rdata === cfg_after, "R11 R12 cfg commit", int'(cfg_rdata), int'(cfg_after));
    cfg_m = cfg_after;
    if (wr) chk(bmem[a[7:0]] === d, "R8 bus write", int'(bmem[a[7:0]]), int'(d));
    if (intrude) begin
      @(negedge clk);
      chk(mem_rd_n === 1'b1 && mem_we_n === 1'b1 && req_ready === 1'b1,
          "R10 intruder ignored", int'(mem_rd_n & mem_we_n), 1);
    end
  endtask

  initial begin
    int seed;
    logic [7:0] c, v;
    int ck;
    seed = 32'h5EED_0042;
    void'($urandom(seed));
    for (int i = 0; i < 256; i++) begin
      bmem[i] = 8'(i * 7 + 3);
      exp_mem[i] = 8'(i * 7 + 3);
    end
    last_rd = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    live = 1'b1;
    // R1 reset state
    chk(cfg_rdata === 8'hFF, "R1 cfg reset", int'(cfg_rdata), 255);
    chk(mem_rd_n === 1'b1 && mem_we_n === 1'b1, "R1 strobes idle", int'(mem_rd_n & mem_we_n), 1);
    chk(mem_dout_oe === 1'b0 && done === 1'b0, "R1 oe done low", int'(mem_dout_oe | done), 0);
    chk(req_ready === 1'b1, "R1 ready", int'(req_ready), 1);
    cfg_m = 8'hFF;
    // slowest default timing, read then write
    run_access(1'b0, 16'h1234, 8'h00, 0, 8'h00, 1'b0, 1'b0);
    run_access(1'b1, 16'h0010, 8'h5A, 0, 8'h00, 1'b0, 1'b0);
    // R3 minimum 4-cycle access
    write_cfg(8'h00);
    run_access(1'b1, 16'h0020, 8'hC3, 0, 8'h00, 1'b0, 1'b0);
    run_access(1'b0, 16'h0020, 8'h00, 0, 8'h00, 1'b0, 1'b0);
    // R2 field positions: setup 1, strobe code 2, hold 2
    write_cfg(8'b01_0010_10);
    run_access(1'b0, 16'h0010, 8'h00, 0, 8'h00, 1'b0, 1'b0);
    // R12 same-cycle write and acceptance
    run_access(1'b0, 16'h0033, 8'h00, 0, 8'b10_0001_01, 1'b1, 1'b0);
    run_access(1'b1, 16'h0044, 8'h77, 0, 8'h00, 1'b0, 1'b0);
    // R11 write during access, R10 intruding request
    run_access(1'b1, 16'h0055, 8'h99, 2, 8'b00_0101_11, 1'b0, 1'b1);
    run_access(1'b0, 16'h0055, 8'h00, 0, 8'h00, 1'b0, 1'b0);
    // constrained random mix
    for (int i = 0; i < 40; i++) begin
      c = 8'($urandom);
      write_cfg(c);
      ck = (i % 4 == 0) ? 1 + int'($urandom % 4) : 0;
      v = 8'($urandom);
      run_access(1'($urandom), {8'($urandom), 8'($urandom % 16)}, 8'($urandom),
                 ck, v, (i % 7 == 3) && (ck == 0), (i % 5 == 1));
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

endmodule